// File: doc/BRIEF.md
# Reverse-Channel Byte Receiver with Run-Length Expansion

This block sits on the host side of a bidirectional parallel port while the port runs in the peripheral-to-host direction. The peripheral presents a byte, marks it as a command or as data with a separate line, and raises a valid strobe. The receiver takes the byte and answers on its host-ack line. It holds that line high until the peripheral drops its strobe. It then keeps the line high for as long as it is still placing bytes into its receive buffer, or for as long as that buffer is full. The host-ack line therefore works as both the handshake and the flow control.

Command bytes never reach the buffer. A command with its top bit clear is a repeat count, and the next data byte is written into the buffer the count plus one times. A command with its top bit set is a channel address. It is reported on a one-cycle strobe together with its value. The buffer is a 16-entry first-word-fall-through queue. A CPU or DMA engine drains it through a pop input, and it reports empty, full and fill level.

The peripheral strobe crosses into the receiver clock through a small synchronizer. Data and the command line are sampled only after the synchronized strobe is seen high. For that reason they must stay stable until host-ack rises.

Top module: `rev_rle_rx`

## Requirements
- R1: After reset, hostAck is low, rxEmpty is high, rxFull is low, rxLevel is 0 and addrStrobe is low.
- R2: When perValid is asserted while hostAck is low, the receiver captures perData and perCmd and raises hostAck. hostAck then stays high for as long as perValid remains high.
- R3: A byte with perCmd=0, arriving when no repeat count is pending, is written to the buffer exactly once. Bytes leave the buffer in arrival order.
- R4: A byte with perCmd=1 and bit 7 equal to 0 is a repeat count N held in bits 6:0 (0 to 127). It is not stored. The next data byte is written N+1 times.
- R5: A pending count applies only to the next data byte; the byte after that is written once. A second count that arrives before any data byte replaces the first.
- R6: A byte with perCmd=1 and bit 7 equal to 1 is a channel address. It is not stored, it cancels any pending count, and it produces a single-cycle addrStrobe with the full byte on addrValue.
- R7: hostAck stays high while a run is still being written. hostAck falls only on a cycle after one in which rxFull was low.
- R8: When the buffer fills during a write or a run, writing stalls with rxFull high and rxLevel equal to 16. Writing resumes as entries are popped, and no entry is lost or duplicated.
- R9: While rxEmpty is low, rxData shows the oldest entry, and rxPop removes it. rxPop while rxEmpty is high has no effect. rxLevel never exceeds 16 and changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rstN | input | 1 | Asynchronous active-low reset |
| perData | input | 8 | Byte driven by the peripheral |
| perCmd | input | 1 | 1 = command byte, 0 = data byte |
| perValid | input | 1 | Peripheral byte-valid strobe, active high, asynchronous |
| hostAck | output | 1 | Handshake and flow-control line back to the peripheral |
| rxPop | input | 1 | Remove the oldest buffer entry |
| rxData | output | 8 | Oldest buffer entry |
| rxEmpty | output | 1 | Buffer holds no entries |
| rxFull | output | 1 | Buffer holds 16 entries |
| rxLevel | output | 5 | Number of entries held |
| addrStrobe | output | 1 | One-cycle pulse on a received channel address |
| addrValue | output | 8 | Last received channel address byte |

## Verification
The bound checker watches several properties on every cycle. It checks that hostAck never falls out of a full-buffer cycle and never falls while the strobe was high. It checks that the buffer never reports empty and full together, that the level stays in range and moves by at most one per cycle, and that the level only grows while hostAck holds the peripheral off. Other behaviour can only be shown by the scenarios the bench drives. This covers how many copies a run produces and their values, that count and address bytes are kept out of the buffer, and that a pending count is cancelled or replaced. It also covers stalling in the middle of a 40-byte run against a full buffer and resuming without loss, and the address strobe with its value.

// File: rtl/rev_rle_pkg.sv
package rev_rle_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_EMIT = 2'd2
  } rxState_t;

  typedef struct packed {
    logic cap;
    logic load;
    logic wr;
  } rxStrobe_t;

endpackage

// File: rtl/rev_rle_ctrl.sv
module rev_rle_ctrl
  import rev_rle_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      perValid,
  input  logic      remainZero,
  input  logic      bufFull,
  output rxStrobe_t stb,
  output logic      hostAck
);

  logic     validS;
  rxState_t state, stateNext;

  generate
    if (SYNC_STAGES == 0) begin : g_noSync
      assign validS = perValid;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] syncReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncReg <= '0;
        end else begin
          syncReg[0] <= perValid;
          for (int i = 1; i < SYNC_STAGES; i++) begin
            syncReg[i] <= syncReg[i-1];
          end
        end
      end
      assign validS = syncReg[SYNC_STAGES-1];
    end
  endgenerate

  always_comb begin
    stateNext = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (validS) begin
          stb.cap   = 1'b1;
          stateNext = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (!validS) begin
          stb.load  = 1'b1;
          stateNext = ST_EMIT;
        end
      end
      ST_EMIT: begin
        if (!remainZero) begin
          stb.wr = !bufFull;
        end else if (!bufFull) begin
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign hostAck = (state != ST_IDLE);

endmodule

// File: rtl/rev_rle_dp.sv
module rev_rle_dp
  import rev_rle_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int PTR_W  = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         stb,
  input  logic [DATA_W-1:0] perData,
  input  logic              perCmd,
  input  logic              rxPop,
  output logic [DATA_W-1:0] rxData,
  output logic              rxEmpty,
  output logic              rxFull,
  output logic [CNT_W-1:0]  rxLevel,
  output logic              addrStrobe,
  output logic [DATA_W-1:0] addrValue,
  output logic              remainZero
);

  localparam int RUN_W = DATA_W - 1;

  logic [DATA_W-1:0] capByte;
  logic              capCmd;
  logic [RUN_W-1:0]  runCnt;
  logic              runPend;
  logic [DATA_W-1:0] remain;

  logic              isAddr;
  logic              isRun;

  assign isAddr = perCmd &&  perData[DATA_W-1];
  assign isRun  = perCmd && !perData[DATA_W-1];

  // capture, command decode and run bookkeeping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capByte    <= '0;
      capCmd     <= 1'b0;
      runCnt     <= '0;
      runPend    <= 1'b0;
      remain     <= '0;
      addrStrobe <= 1'b0;
      addrValue  <= '0;
    end else begin
      addrStrobe <= 1'b0;
      if (stb.cap) begin
        capByte <= perData;
        capCmd  <= perCmd;
        if (isAddr) begin
          addrStrobe <= 1'b1;
          addrValue  <= perData;
          runPend    <= 1'b0;
        end else if (isRun) begin
          runCnt  <= perData[RUN_W-1:0];
          runPend <= 1'b1;
        end
      end
      if (stb.load) begin
        if (!capCmd) begin
          remain  <= runPend ? ({1'b0, runCnt} + DATA_W'(1)) : DATA_W'(1);
          runPend <= 1'b0;
        end else begin
          remain <= '0;
        end
      end else if (stb.wr) begin
        remain <= remain - DATA_W'(1);
      end
    end
  end

  assign remainZero = (remain == '0);

  // receive buffer
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              push, pop;
  logic [PTR_W-1:0]  wrPtrNext, rdPtrNext;

  assign push = stb.wr;
  assign pop  = rxPop && (count != '0);

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wrPtrNext = wrPtr + PTR_W'(1);
      assign rdPtrNext = rdPtr + PTR_W'(1);
    end else begin : g_wrap
      assign wrPtrNext = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      assign rdPtrNext = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= capByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtrNext;
      if (pop)  rdPtr <= rdPtrNext;
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign rxData  = mem[rdPtr];
  assign rxEmpty = (count == '0);
  assign rxFull  = (count == CNT_W'(DEPTH));
  assign rxLevel = count;

endmodule

// File: rtl/rev_rle_rx.sv
module rev_rle_rx
  import rev_rle_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] perData,
  input  logic              perCmd,
  input  logic              perValid,
  output logic              hostAck,
  input  logic              rxPop,
  output logic [DATA_W-1:0] rxData,
  output logic              rxEmpty,
  output logic              rxFull,
  output logic [CNT_W-1:0]  rxLevel,
  output logic              addrStrobe,
  output logic [DATA_W-1:0] addrValue
);

  rxStrobe_t stb;
  logic      remainZero;

  rev_rle_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .perValid  (perValid),
    .remainZero(remainZero),
    .bufFull   (rxFull),
    .stb       (stb),
    .hostAck   (hostAck)
  );

  rev_rle_dp #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH),
    .PTR_W (PTR_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .perData   (perData),
    .perCmd    (perCmd),
    .rxPop     (rxPop),
    .rxData    (rxData),
    .rxEmpty   (rxEmpty),
    .rxFull    (rxFull),
    .rxLevel   (rxLevel),
    .addrStrobe(addrStrobe),
    .addrValue (addrValue),
    .remainZero(remainZero)
  );

endmodule

// File: rtl/rev_rle_rx_checker.sv
module rev_rle_rx_checker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             perValid,
  input logic             hostAck,
  input logic             rxEmpty,
  input logic             rxFull,
  input logic [CNT_W-1:0] rxLevel
);

  AST_ACK_FALL_SPACE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostAck) |-> !$past(rxFull)) else $error("hostAck fell while full"); // R7

  AST_ACK_HELD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostAck) |-> !$past(perValid)) else $error("hostAck fell under valid"); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    rxLevel <= CNT_W'(DEPTH)) else $error("level above depth"); // R9

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rxEmpty && rxFull)) else $error("empty and full together"); // R9

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel == $past(rxLevel)) || (rxLevel == $past(rxLevel) + CNT_W'(1)) ||
    (rxLevel + CNT_W'(1) == $past(rxLevel))) else $error("level jumped"); // R9

  AST_GROW_UNDER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel > $past(rxLevel)) |-> $past(hostAck)) else $error("write without hold-off"); // R7

endmodule

bind rev_rle_rx rev_rle_rx_checker #(
  .DEPTH(DEPTH),
  .CNT_W(CNT_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .perValid(perValid),
  .hostAck (hostAck),
  .rxEmpty (rxEmpty),
  .rxFull  (rxFull),
  .rxLevel (rxLevel)
);

// File: tb/rev_rle_rx_bench.sv
`timescale 1ns/1ps
module rev_rle_rx_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] perData = '0;
  logic       perCmd = 1'b0;
  logic       perValid = 1'b0;
  logic       hostAck;
  logic       rxPop = 1'b0;
  logic [7:0] rxData;
  logic       rxEmpty, rxFull;
  logic [4:0] rxLevel;
  logic       addrStrobe;
  logic [7:0] addrValue;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] expQ[$];
  bit         consume = 1'b1;
  bit         forcePop = 1'b0;
  bit         runPend = 1'b0;
  int         runLen = 0;
  logic [7:0] expAddr = '0;
  int         addrSeen = 0;

  always #2 clk = ~clk;

  rev_rle_rx u_rev_rle_rx (
    .clk(clk), .rstN(rstN), .perData(perData), .perCmd(perCmd),
    .perValid(perValid), .hostAck(hostAck), .rxPop(rxPop), .rxData(rxData),
    .rxEmpty(rxEmpty), .rxFull(rxFull), .rxLevel(rxLevel),
    .addrStrobe(addrStrobe), .addrValue(addrValue)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // driver: one handshake, also pushes the expected buffer entries
  task automatic sendRaw(input logic cmd, input logic [7:0] b);
    @(negedge clk);
    while (hostAck) @(negedge clk);
    if (!cmd) begin
      int n = runPend ? runLen + 1 : 1;
      for (int k = 0; k < n; k++) expQ.push_back(b);
      runPend = 1'b0;
    end else if (b[7]) begin
      expAddr = b;
      runPend = 1'b0;
    end else begin
      runPend = 1'b1;
      runLen  = int'(b[6:0]);
    end
    perData  = b;
    perCmd   = cmd;
    perValid = 1'b1;
    while (!hostAck) @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      check("R2 hostAck held while valid", hostAck, 1'b1);
    end
    perValid = 1'b0;
  endtask

  task automatic sendData(input logic [7:0] b); sendRaw(1'b0, b); endtask
  task automatic sendRun(input int n);          sendRaw(1'b1, 8'(n)); endtask
  task automatic sendAddr(input logic [7:0] a); sendRaw(1'b1, a); endtask

  task automatic drain();
    int guard = 0;
    while ((expQ.size() != 0 || hostAck || !rxEmpty) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check("R8 all expected entries delivered", expQ.size(), 0);
  endtask

  // monitor: pops and compares against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      rxPop = 1'b0;
      if (rstN && consume && !rxEmpty) begin
        if (expQ.size() == 0) begin
          check("R3 unexpected entry", rxData, 8'hxx);
        end else begin
          check("R3 R4 entry order and value", rxData, expQ.pop_front());
        end
        rxPop = 1'b1;
      end else if (forcePop) begin
        rxPop = 1'b1;
      end
      if (rstN && addrStrobe) begin
        addrSeen++;
        check("R6 address value", addrValue, expAddr);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int seen;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 hostAck", hostAck, 1'b0);
    check("R1 empty", rxEmpty, 1'b1);
    check("R1 full", rxFull, 1'b0);
    check("R1 level", rxLevel, 0);
    check("R1 addrStrobe", addrStrobe, 1'b0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R3 plain data
    sendData(8'h11); sendData(8'h22); sendData(8'h33);
    drain();

    // R4 run of 1 (N=0) and run of 6 (N=5); R5 next byte once
    sendRun(0);  sendData(8'hA0);
    sendRun(5);  sendData(8'hA5); sendData(8'hB1);
    drain();

    // R5 second count replaces the first
    sendRun(9); sendRun(2); sendData(8'hC2); sendData(8'hC3);
    drain();

    // R6 address cancels a pending count and is not stored
    seen = addrSeen;
    sendRun(7); sendAddr(8'h85); sendData(8'hD1);
    drain();
    check("R6 one address strobe", addrSeen - seen, 1);

    // R9 pop on empty ignored
    consume = 1'b0;
    forcePop = 1'b1;
    repeat (4) @(negedge clk);
    forcePop = 1'b0;
    @(negedge clk);
    check("R9 empty after pop on empty", rxEmpty, 1'b1);
    check("R9 level after pop on empty", rxLevel, 0);

    // R7 R8 back-pressure from plain data
    for (int i = 0; i < 16; i++) sendData(8'(8'h40 + i));
    repeat (20) @(negedge clk);
    check("R8 full flag", rxFull, 1'b1);
    check("R8 level at depth", rxLevel, 16);
    check("R7 hostAck held while full", hostAck, 1'b1);
    consume = 1'b1;
    drain();

    // R7 R8 stall in the middle of a 40-byte run
    consume = 1'b0;
    sendRun(39); sendData(8'h5A);
    repeat (100) @(negedge clk);
    check("R8 level at depth mid-run", rxLevel, 16);
    check("R7 hostAck held mid-run", hostAck, 1'b1);
    consume = 1'b1;
    drain();

    // R4 longest run, N=127 gives 128 copies
    sendRun(127); sendData(8'hE7); sendData(8'hE8);
    drain();
    check("R1 hostAck idle at end", hostAck, 1'b0);
    check("R9 empty at end", rxEmpty, 1'b1);
    finishRun();
  end

endmodule